// File: doc/BRIEF.md
# Accumulator Memory-Reference Executor

This block carries out the memory-touching instructions of a small 12-bit accumulator processor. It holds the accumulator, a one-bit Link and the program counter. It accepts one already decoded instruction at a time: a 3-bit operation code, an indirect flag and an effective address Y. It then runs the memory traffic that the instruction needs against a synchronous word memory with one cycle of read latency. That traffic is the optional pointer read, then the operand read or write, then the read-modify-write of a counter word. Last, it updates AC, Link and PC.

An enclosing core fetches an instruction, forms Y and pulses `start_i` while `busy_o` is low. It then waits for `done_o`, which marks the cycle in which the new AC, Link and PC are visible. The PC is assumed to point at the word after the instruction being executed, so a plain operand access leaves it alone. Only a skip, a jump or a call moves it. An indirect jump through the word that a call wrote is the return from a subroutine.

Top module: `mre_exec`

## Requirements
- R1: Operation code 0 replaces AC with the bitwise AND of AC and the word at the effective address. Link, PC and memory are unchanged.
- R2: Operation code 1 adds the word at the effective address to AC modulo 4096. A carry out of bit 11 inverts the Link, and no carry leaves the Link as it was.
- R3: Operation code 2 writes the word at the effective address plus one (modulo 4096) back to that address. If the written value is zero, PC advances by one. AC and Link are untouched.
- R4: Operation code 3 writes AC to the effective address and then sets AC to zero.
- R5: Operation code 4 writes the current PC to the effective address Y and loads PC with Y+1 modulo 4096. AC and Link are untouched.
- R6: Operation code 5 loads PC with the effective address. AC, Link and memory are untouched.
- R7: With the indirect flag set, the block first reads location Y, and the value read is the effective address used by the operation. An indirect jump through a word written by operation code 4 returns to the saved PC.
- R8: `done_o` rises the given number of cycles after the clock edge that accepts `start_i`. Direct operations 3, 4 and 5 take 1 cycle. Direct operations 0, 1 and 2 take 2 cycles. The indirect flag adds 2 cycles, except that an indirect jump takes 2 cycles in total.
- R9: `done_o` is a one-cycle pulse. `busy_o` is high from the accepting edge until `done_o`. `start_i` is ignored while `busy_o` is high, and a new start is accepted in the same cycle as `done_o`.
- R10: Operation codes 6 and 7 change no register and write no memory. They report `done_o` 1 cycle after acceptance whatever the indirect flag is.
- R11: After reset, AC, Link and PC are zero, and `busy_o`, `done_o` and `mem_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin the presented instruction (taken only while idle) |
| op_i | input | 3 | Operation code |
| ind_i | input | 1 | Indirect addressing flag |
| addr_i | input | 12 | Effective address Y |
| busy_o | output | 1 | An instruction is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ac_o | output | 12 | Accumulator |
| link_o | output | 1 | Link bit |
| pc_o | output | 12 | Program counter |
| mem_addr_o | output | 12 | Memory word address |
| mem_wdata_o | output | 12 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 12 | Memory read data, one cycle after the address |

## Verification
Every result is due a fixed number of cycles after the accepting edge. That number is 1 for a direct store, call, jump or unused code. It is 2 for a direct AND, add or increment-and-skip, and 2 more for indirection, except that an indirect jump totals 2. AC, Link, PC and memory change on the same edge that raises `done_o`. The bench model keeps a countdown loaded with that latency at acceptance and applies the expected register values when it expires. It compares done, busy, AC, Link and PC at every falling edge, so an early or late result shows up as a mismatch in that exact cycle. Memory contents are checked after `busy_o` falls, before the next instruction can write.

// File: rtl/mre_pkg.sv
package mre_pkg;

   typedef enum logic [2:0] {
      OPC_AND  = 3'd0,
      OPC_ADD  = 3'd1,
      OPC_INCS = 3'd2,
      OPC_STCL = 3'd3,
      OPC_CALL = 3'd4,
      OPC_JUMP = 3'd5,
      OPC_RSV6 = 3'd6,
      OPC_RSV7 = 3'd7
   } opc_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PTR_A = 3'd1,
      ST_PTR_D = 3'd2,
      ST_EXEC  = 3'd3,
      ST_DATA  = 3'd4
   } seq_e;

   function automatic logic reads_operand(input logic [2:0] op);
      return (op == OPC_AND) || (op == OPC_ADD) || (op == OPC_INCS);
   endfunction

endpackage

// File: rtl/mre_alu.sv
module mre_alu #(
   parameter int WORD_W       = 12,
   parameter bit ADDER_RIPPLE = 1'b1
) (
   input  logic [WORD_W-1:0] ac_i,
   input  logic [WORD_W-1:0] mem_i,
   output logic [WORD_W-1:0] and_o,
   output logic [WORD_W-1:0] sum_o,
   output logic              carry_o,
   output logic [WORD_W-1:0] inc_o,
   output logic              inc_zero_o
);

   localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

   assign and_o = ac_i & mem_i;

   generate
      if (ADDER_RIPPLE) begin : g_ripple
         logic [WORD_W:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < WORD_W; i++) begin : g_bit
            assign sum_o[i]  = ac_i[i] ^ mem_i[i] ^ cy[i];
            assign cy[i+1]   = (ac_i[i] & mem_i[i]) | (cy[i] & (ac_i[i] ^ mem_i[i]));
         end
         assign carry_o = cy[WORD_W];
      end else begin : g_behav
         assign {carry_o, sum_o} = {1'b0, ac_i} + {1'b0, mem_i};
      end
   endgenerate

   assign inc_o      = mem_i + ONE;
   assign inc_zero_o = (inc_o == '0);

endmodule

// File: rtl/mre_seq.sv
module mre_seq
   import mre_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [2:0] op_i,
   input  logic       ind_i,
   input  logic [2:0] op_q_i,
   output seq_e       state_o,
   output logic       finish_o
);

   seq_e state_q, state_d;

   always_comb begin
      state_d  = state_q;
      finish_o = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               if (ind_i && (op_i != OPC_RSV6) && (op_i != OPC_RSV7))
                  state_d = ST_PTR_A;
               else
                  state_d = ST_EXEC;
            end
         end
         ST_PTR_A: state_d = ST_PTR_D;
         ST_PTR_D: begin
            if (op_q_i == OPC_JUMP) begin
               state_d  = ST_IDLE;
               finish_o = 1'b1;
            end else begin
               state_d = ST_EXEC;
            end
         end
         ST_EXEC: begin
            if (reads_operand(op_q_i)) begin
               state_d = ST_DATA;
            end else begin
               state_d  = ST_IDLE;
               finish_o = 1'b1;
            end
         end
         ST_DATA: begin
            state_d  = ST_IDLE;
            finish_o = 1'b1;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/mre_exec.sv
module mre_exec
   import mre_pkg::*;
#(
   parameter int WORD_W       = 12,
   parameter bit ADDER_RIPPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        op_i,
   input  logic              ind_i,
   input  logic [WORD_W-1:0] addr_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [WORD_W-1:0] ac_o,
   output logic              link_o,
   output logic [WORD_W-1:0] pc_o,
   output logic [WORD_W-1:0] mem_addr_o,
   output logic [WORD_W-1:0] mem_wdata_o,
   output logic              mem_we_o,
   input  logic [WORD_W-1:0] mem_rdata_i
);

   localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

   generate
      if (WORD_W < 4) begin : g_bad_width
         $error("mre_exec: WORD_W must be at least 4");
      end
   endgenerate

   seq_e              state;
   logic              finish;
   logic [2:0]        op_q;
   logic [WORD_W-1:0] ea_q;
   logic [WORD_W-1:0] ac_q, pc_q;
   logic              link_q, done_q;

   logic [WORD_W-1:0] and_res, sum_res, inc_res;
   logic              add_cy, inc_zero;

   mre_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .op_i     (op_i),
      .ind_i    (ind_i),
      .op_q_i   (op_q),
      .state_o  (state),
      .finish_o (finish)
   );

   mre_alu #(.WORD_W(WORD_W), .ADDER_RIPPLE(ADDER_RIPPLE)) u_alu (
      .ac_i       (ac_q),
      .mem_i      (mem_rdata_i),
      .and_o      (and_res),
      .sum_o      (sum_res),
      .carry_o    (add_cy),
      .inc_o      (inc_res),
      .inc_zero_o (inc_zero)
   );

   // instruction capture and pointer follow
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q <= '0;
         ea_q <= '0;
      end else if (state == ST_IDLE && start_i) begin
         op_q <= op_i;
         ea_q <= addr_i;
      end else if (state == ST_PTR_D) begin
         ea_q <= mem_rdata_i;
      end
   end

   // architectural registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ac_q   <= '0;
         link_q <= 1'b0;
         pc_q   <= '0;
      end else begin
         unique case (state)
            ST_PTR_D: if (op_q == OPC_JUMP) pc_q <= mem_rdata_i;
            ST_EXEC: begin
               if (op_q == OPC_STCL) ac_q <= '0;
               if (op_q == OPC_CALL) pc_q <= ea_q + ONE;
               if (op_q == OPC_JUMP) pc_q <= ea_q;
            end
            ST_DATA: begin
               if (op_q == OPC_AND) ac_q <= and_res;
               if (op_q == OPC_ADD) begin
                  ac_q <= sum_res;
                  if (add_cy) link_q <= ~link_q;
               end
               if (op_q == OPC_INCS && inc_zero) pc_q <= pc_q + ONE;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= finish;
   end

   always_comb begin
      mem_we_o    = 1'b0;
      mem_wdata_o = ac_q;
      if (state == ST_EXEC && op_q == OPC_STCL) begin
         mem_we_o = 1'b1;
      end else if (state == ST_EXEC && op_q == OPC_CALL) begin
         mem_we_o    = 1'b1;
         mem_wdata_o = pc_q;
      end else if (state == ST_DATA && op_q == OPC_INCS) begin
         mem_we_o    = 1'b1;
         mem_wdata_o = inc_res;
      end
   end

   assign mem_addr_o = ea_q;
   assign busy_o     = (state != ST_IDLE);
   assign done_o     = done_q;
   assign ac_o       = ac_q;
   assign link_o     = link_q;
   assign pc_o       = pc_q;

endmodule

// File: rtl/mre_exec_chk.sv
module mre_exec_chk #(
   parameter int WORD_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [WORD_W-1:0] ac_o,
   input logic              link_o,
   input logic [WORD_W-1:0] pc_o,
   input logic              mem_we_o
);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R9
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);

   // R8
   ac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ac_o) |-> done_o);

   // R8
   pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pc_o) |-> done_o);

   // R8
   link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(link_o) |-> done_o);

   // R11
   write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> busy_o);

endmodule

bind mre_exec mre_exec_chk #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .ac_o     (ac_o),
   .link_o   (link_o),
   .pc_o     (pc_o),
   .mem_we_o (mem_we_o)
);

// File: tb/mre_exec_tb.sv
module mre_exec_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  op_i = '0;
   logic        ind_i = 1'b0;
   logic [11:0] addr_i = '0;
   logic        busy_o, done_o, link_o, mem_we_o;
   logic [11:0] ac_o, pc_o, mem_addr_o, mem_wdata_o;
   logic [11:0] mem_rdata_i = '0;

   always #5 clk = ~clk;

   mre_exec u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .ind_i(ind_i),
      .addr_i(addr_i), .busy_o(busy_o), .done_o(done_o), .ac_o(ac_o),
      .link_o(link_o), .pc_o(pc_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o), .mem_rdata_i(mem_rdata_i)
   );

   // memory seen by the design
   logic [11:0] mem  [0:4095];
   // memory as the model expects it
   logic [11:0] rmem [0:4095];

   always @(posedge clk) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      mem_rdata_i <= mem[mem_addr_o];
   end

   int n_cmp = 0;
   int n_bad = 0;
   string cur_req = "R11";

   // reference model state
   logic [11:0] e_ac = '0, e_pc = '0, n_ac = '0, n_pc = '0;
   logic        e_link = 1'b0, n_link = 1'b0, e_busy = 1'b0, e_done = 1'b0;
   int          cnt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         e_ac = '0; e_pc = '0; e_link = 1'b0; e_busy = 1'b0; e_done = 1'b0; cnt = 0;
      end else if (e_busy) begin
         cnt = cnt - 1;
         if (cnt == 0) begin
            e_ac = n_ac; e_link = n_link; e_pc = n_pc;
            e_done = 1'b1; e_busy = 1'b0;
         end
      end else begin
         e_done = 1'b0;
         if (start_i) begin
            logic [11:0] ea;
            logic [12:0] s;
            n_ac = e_ac; n_link = e_link; n_pc = e_pc;
            ea = (ind_i && op_i < 3'd6) ? rmem[addr_i] : addr_i;
            case (op_i)
               3'd0: n_ac = e_ac & rmem[ea];
               3'd1: begin
                  s = {1'b0, e_ac} + {1'b0, rmem[ea]};
                  n_ac = s[11:0];
                  if (s[12]) n_link = ~e_link;
               end
               3'd2: begin
                  rmem[ea] = rmem[ea] + 12'd1;
                  if (rmem[ea] == 12'd0) n_pc = e_pc + 12'd1;
               end
               3'd3: begin rmem[ea] = e_ac; n_ac = '0; end
               3'd4: begin rmem[ea] = e_pc; n_pc = ea + 12'd1; end
               3'd5: n_pc = ea;
               default: ;
            endcase
            if (op_i >= 3'd6)                       cnt = 1;
            else if (op_i == 3'd5)                  cnt = ind_i ? 2 : 1;
            else if (op_i == 3'd3 || op_i == 3'd4)  cnt = ind_i ? 3 : 1;
            else                                    cnt = ind_i ? 4 : 2;
            e_busy = 1'b1;
         end
      end
   end

   task automatic cmp(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0o expected=%0o t=%0t", req, what, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         cmp("R8", "done", int'(done_o), int'(e_done));
         cmp("R9", "busy", int'(busy_o), int'(e_busy));
         cmp(cur_req, "ac", int'(ac_o), int'(e_ac));
         cmp(cur_req, "link", int'(link_o), int'(e_link));
         cmp(cur_req, "pc", int'(pc_o), int'(e_pc));
         if (!e_busy) cmp("R11", "we_idle", int'(mem_we_o), 0);
      end
   end

   task automatic wait_idle();
      int guard = 0;
      @(negedge clk);
      while (e_busy) begin
         @(negedge clk);
         guard++;
         if (guard > 50) begin
            cmp("R9", "watchdog", 1, 0);
            break;
         end
      end
   endtask

   task automatic run(string req, logic [2:0] op, logic ind, logic [11:0] y);
      cur_req = req;
      op_i = op; ind_i = ind; addr_i = y; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (e_busy) @(negedge clk);
   endtask

   task automatic chk_mem(string req, logic [11:0] a);
      cmp(req, "mem", int'(mem[a]), int'(rmem[a]));
   endtask

   task automatic put(logic [11:0] a, logic [11:0] v);
      mem[a] = v; rmem[a] = v;
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) begin mem[i] = '0; rmem[i] = '0; end
      put(12'o100, 12'o7777);
      put(12'o101, 12'o0001);
      put(12'o102, 12'o0005);
      put(12'o103, 12'o0006);
      put(12'o111, 12'o7777);
      put(12'o112, 12'o0005);
      put(12'o120, 12'o0100);
      put(12'o121, 12'o0130);
      put(12'o122, 12'o0103);
      put(12'o140, 12'o1234);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state observed by the per-cycle compares, plus explicit checks
      cmp("R11", "ac_reset", int'(ac_o), 0);
      cmp("R11", "pc_reset", int'(pc_o), 0);
      cmp("R11", "busy_reset", int'(busy_o), 0);

      run("R2", 3'd1, 1'b0, 12'o100);   // 0 + 7777, no carry
      run("R2", 3'd1, 1'b0, 12'o101);   // 7777 + 1 wraps, Link flips
      run("R2", 3'd1, 1'b0, 12'o102);   // 0 + 5
      cmp("R2", "ac_after_add", int'(ac_o), 12'o0005);
      cmp("R2", "link_after_carry", int'(link_o), 1);
      run("R1", 3'd0, 1'b0, 12'o103);   // 5 & 6 = 4
      cmp("R1", "and_result", int'(ac_o), 12'o0004);
      chk_mem("R1", 12'o103);
      run("R4", 3'd3, 1'b0, 12'o110);
      wait_idle();
      chk_mem("R4", 12'o110);
      cmp("R4", "ac_cleared", int'(ac_o), 0);
      run("R3", 3'd2, 1'b0, 12'o111);   // 7777 -> 0 skips
      wait_idle();
      chk_mem("R3", 12'o111);
      cmp("R3", "pc_skip", int'(pc_o), 1);
      run("R3", 3'd2, 1'b0, 12'o112);   // 5 -> 6 no skip
      wait_idle();
      chk_mem("R3", 12'o112);
      run("R6", 3'd5, 1'b0, 12'o200);
      cmp("R6", "pc_jump", int'(pc_o), 12'o0200);
      run("R5", 3'd4, 1'b0, 12'o300);
      wait_idle();
      chk_mem("R5", 12'o300);
      cmp("R5", "pc_call", int'(pc_o), 12'o0301);
      run("R7", 3'd5, 1'b1, 12'o300);   // return through saved PC
      cmp("R7", "pc_return", int'(pc_o), 12'o0200);
      run("R7", 3'd1, 1'b1, 12'o120);   // add through pointer to 100
      run("R7", 3'd3, 1'b1, 12'o121);   // store through pointer to 130
      wait_idle();
      chk_mem("R7", 12'o130);
      run("R7", 3'd0, 1'b1, 12'o122);
      run("R10", 3'd6, 1'b1, 12'o140);
      run("R10", 3'd7, 1'b0, 12'o140);
      wait_idle();
      chk_mem("R10", 12'o140);
      run("R2", 3'd1, 1'b0, 12'o100);
      // R9: start presented during a busy indirect add must be ignored
      cur_req = "R9";
      op_i = 3'd1; ind_i = 1'b1; addr_i = 12'o120; start_i = 1'b1;
      @(negedge clk);
      op_i = 3'd3; ind_i = 1'b0; addr_i = 12'o140;
      @(negedge clk);
      start_i = 1'b0;
      wait_idle();
      wait_idle();
      chk_mem("R9", 12'o140);
      cmp("R9", "mem_untouched", int'(mem[12'o140]), 12'o1234);
      run("R8", 3'd5, 1'b0, 12'o7777);
      run("R5", 3'd4, 1'b0, 12'o7777);  // Y+1 wraps to 0
      wait_idle();
      chk_mem("R5", 12'o7777);
      cmp("R5", "pc_wrap", int'(pc_o), 0);
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_cmp++; n_bad++;
         $display("FAIL R9 global watchdog actual=%0d expected=%0d", cyc, 100000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule